// File: doc/BRIEF.md
# Region Protection and Cache-Attribute Unit

This unit checks memory accesses for a core that has no paging hardware. The 4 GB address space is cut into eight fixed 512 MB regions, and the top three address bits select one. A per-region 4-bit attribute gives read, write and execute rights and a cache policy: bypass, write-through, write-back or isolate. Each request names an access kind: load, store or fetch. The unit answers with the physical address, the rights, the policy and a cause code. The cause code is zero when the access is allowed, and otherwise gives a distinct code for each denied kind.

Two modes are chosen by a plain control pin. In region mode, each region holds its own physical base and attribute, and the physical address is that base with the low 29 address bits kept. In plain mode, the address passes through unchanged, and the attribute is the region's nibble of a packed 32-bit cache-attribute register. Region entries and the cache-attribute register are written through plain write ports.

Requests and responses flow over valid/ready handshakes with a single registered response stage. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle, so a stalled consumer stops new requests. While `rsp_valid` is high and `rsp_ready` is low, every response field is held.

Top module: `rpu_unit`

## Requirements
- R1: After reset, `rsp_valid` is 0, every region maps identity with attribute 2, and the cache-attribute register holds 0x22222222. Any first lookup therefore returns paddr equal to vaddr, rights RWX, policy bypass and cause 0.
- R2: The region index is vaddr[31:29]. In region mode the physical address is the region base (bits 31:29 of the written base; lower base bits are dropped) concatenated with vaddr[28:0].
- R3: In plain mode the physical address equals vaddr. The attribute is bits [4*i+3:4*i] of the cache-attribute register, where i is the region index.
- R4: The attribute decodes as follows, with `rsp_cache` coded 0 none, 1 bypass, 2 write-through, 3 write-back, 4 isolate. Code 0 is RW write-through. Code 1 is RWX write-through. Code 2 is RWX bypass. Code 3 is X only with write-back. Code 4 is RWX write-back. Code 14 is RW isolate. Every other code gives no rights and policy 0, apart from the case in R5.
- R5: Attribute code 5 means RWX write-back in region mode and no rights, policy 0, in plain mode.
- R6: `req_kind` is coded 0 load, 1 store, 2 or 3 fetch. The cause is 0 when the needed right (R, W or X) is present. Otherwise it is 2 for a denied load, 3 for a denied store and 1 for a denied fetch.
- R7: An entry or cache-attribute write takes effect at the clock edge where it is applied. A request accepted at that same edge still sees the old value.
- R8: A request accepted at an edge is presented with `rsp_valid` high after that edge. `req_ready` equals (not `rsp_valid`) or `rsp_ready`.
- R9: While `rsp_valid` is high and `rsp_ready` is low, all response fields stay stable and no request is accepted, even if configuration writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| region_mode | input | 1 | 1 selects region mode, 0 selects plain mode |
| cfg_ent_we | input | 1 | Region entry write strobe |
| cfg_ent_idx | input | 3 | Region entry to write |
| cfg_ent_base | input | 32 | New region base (bits 31:29 kept) |
| cfg_ent_attr | input | 4 | New region attribute |
| cfg_ca_we | input | 1 | Cache-attribute register write strobe |
| cfg_ca_data | input | 32 | New cache-attribute register value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind (0 load, 1 store, 2/3 fetch) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 32 | Physical address |
| rsp_cause | output | 2 | 0 allowed, 1 fetch denied, 2 load denied, 3 store denied |
| rsp_rd | output | 1 | Read right |
| rsp_wr | output | 1 | Write right |
| rsp_ex | output | 1 | Execute right |
| rsp_cache | output | 3 | Cache policy code |

## Verification
The properties assume that every input is at a known level outside reset. They also assume that `req_vaddr` is meaningful whenever `req_valid` is high, because the offset check compares the response against the address seen at the accepting edge. The bench drives all inputs at the falling edge and never leaves them unknown. It picks `req_kind` from all four codes and attributes from all sixteen. It stalls the consumer only in directed sequences that hold a new request and a configuration write against the full stage.

// File: rtl/rpu_pkg.sv
package rpu_pkg;

  typedef enum logic [2:0] {
    CP_NONE    = 3'd0,
    CP_BYPASS  = 3'd1,
    CP_WTHRU   = 3'd2,
    CP_WBACK   = 3'd3,
    CP_ISOLATE = 3'd4
  } cache_pol_e;

  typedef enum logic [1:0] {
    CS_OK         = 2'd0,
    CS_FETCH_DENY = 2'd1,
    CS_LOAD_DENY  = 2'd2,
    CS_STORE_DENY = 2'd3
  } cause_e;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       ex;
    cache_pol_e pol;
  } perm_t;

endpackage

// File: rtl/rpu_region_table.sv
module rpu_region_table #(
  parameter int IDX_W    = 3,
  parameter int ATTR_W   = 4,
  parameter int RST_ATTR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  wr_base,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  rd_base,
  output logic [ATTR_W-1:0] rd_attr
);
  localparam int NREG = 1 << IDX_W;
  localparam logic [ATTR_W-1:0] RST_NIB = ATTR_W'(RST_ATTR);

  logic [IDX_W-1:0]  base_all [NREG];
  logic [ATTR_W-1:0] attr_all [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    logic              hit;
    logic [IDX_W-1:0]  base_q;
    logic [ATTR_W-1:0] attr_q;

    assign hit = wr_en && (wr_idx == MY_IDX);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q <= MY_IDX;
        attr_q <= RST_NIB;
      end else if (hit) begin
        base_q <= wr_base;
        attr_q <= wr_attr;
      end
    end

    assign base_all[g] = base_q;
    assign attr_all[g] = attr_q;
  end

  assign rd_base = base_all[rd_idx];
  assign rd_attr = attr_all[rd_idx];
endmodule

// File: rtl/rpu_attr_select.sv
module rpu_attr_select #(
  parameter int IDX_W    = 3,
  parameter int ATTR_W   = 4,
  parameter int RST_ATTR = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ca_we,
  input  logic [(ATTR_W<<IDX_W)-1:0] ca_data,
  input  logic                       region_mode,
  input  logic [IDX_W-1:0]           idx,
  input  logic [ATTR_W-1:0]          region_attr,
  output logic [ATTR_W-1:0]          attr
);
  localparam int NREG = 1 << IDX_W;
  localparam int CA_W = ATTR_W * NREG;
  localparam logic [ATTR_W-1:0] RST_NIB = ATTR_W'(RST_ATTR);

  logic [CA_W-1:0]   ca_q;
  logic [ATTR_W-1:0] nib [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n)     ca_q <= {NREG{RST_NIB}};
    else if (ca_we) ca_q <= ca_data;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_nib
    assign nib[g] = ca_q[g*ATTR_W +: ATTR_W];
  end

  assign attr = region_mode ? region_attr : nib[idx];
endmodule

// File: rtl/rpu_attr_decode.sv
module rpu_attr_decode
  import rpu_pkg::*;
#(
  parameter int ATTR_W = 4
) (
  input  logic [ATTR_W-1:0] attr,
  input  logic              region_mode,
  output perm_t             perm
);
  always_comb begin
    perm = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, pol: CP_NONE};
    case (attr)
      ATTR_W'(0):  perm = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, pol: CP_WTHRU};
      ATTR_W'(1):  perm = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: CP_WTHRU};
      ATTR_W'(2):  perm = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: CP_BYPASS};
      ATTR_W'(3):  perm = '{rd: 1'b0, wr: 1'b0, ex: 1'b1, pol: CP_WBACK};
      ATTR_W'(4):  perm = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: CP_WBACK};
      ATTR_W'(5):  if (region_mode)
                     perm = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: CP_WBACK};
      ATTR_W'(14): perm = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, pol: CP_ISOLATE};
      default:     ;
    endcase
  end
endmodule

// File: rtl/rpu_resp_stage.sv
module rpu_resp_stage #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay
);
  logic             vld_q;
  logic [PAY_W-1:0] pay_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_pay   = pay_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pay_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) pay_q <= in_pay;
    end
  end
endmodule

// File: rtl/rpu_unit.sv
module rpu_unit
  import rpu_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 3,
  parameter int ATTR_W   = 4,
  parameter int RST_ATTR = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       region_mode,
  input  logic                       cfg_ent_we,
  input  logic [IDX_W-1:0]           cfg_ent_idx,
  input  logic [ADDR_W-1:0]          cfg_ent_base,
  input  logic [ATTR_W-1:0]          cfg_ent_attr,
  input  logic                       cfg_ca_we,
  input  logic [(ATTR_W<<IDX_W)-1:0] cfg_ca_data,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_vaddr,
  input  logic [1:0]                 req_kind,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [ADDR_W-1:0]          rsp_paddr,
  output logic [1:0]                 rsp_cause,
  output logic                       rsp_rd,
  output logic                       rsp_wr,
  output logic                       rsp_ex,
  output logic [2:0]                 rsp_cache
);
  localparam int OFF_W = ADDR_W - IDX_W;

  typedef struct packed {
    logic [ADDR_W-1:0] paddr;
    cause_e            cause;
    perm_t             perm;
  } resp_t;

  localparam int PAY_W = $bits(resp_t);

  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  reg_base;
  logic [ATTR_W-1:0] reg_attr;
  logic [ATTR_W-1:0] sel_attr;
  perm_t             perm;
  resp_t             nxt, cur;
  logic [PAY_W-1:0]  cur_bits;

  assign idx = req_vaddr[ADDR_W-1 -: IDX_W];

  rpu_region_table #(.IDX_W(IDX_W), .ATTR_W(ATTR_W), .RST_ATTR(RST_ATTR)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_ent_we),
    .wr_idx  (cfg_ent_idx),
    .wr_base (cfg_ent_base[ADDR_W-1 -: IDX_W]),
    .wr_attr (cfg_ent_attr),
    .rd_idx  (idx),
    .rd_base (reg_base),
    .rd_attr (reg_attr)
  );

  rpu_attr_select #(.IDX_W(IDX_W), .ATTR_W(ATTR_W), .RST_ATTR(RST_ATTR)) u_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .ca_we       (cfg_ca_we),
    .ca_data     (cfg_ca_data),
    .region_mode (region_mode),
    .idx         (idx),
    .region_attr (reg_attr),
    .attr        (sel_attr)
  );

  rpu_attr_decode #(.ATTR_W(ATTR_W)) u_dec (
    .attr        (sel_attr),
    .region_mode (region_mode),
    .perm        (perm)
  );

  always_comb begin
    nxt.perm  = perm;
    nxt.paddr = region_mode ? {reg_base, req_vaddr[OFF_W-1:0]} : req_vaddr;
    if (req_kind[1])            nxt.cause = perm.ex ? CS_OK : CS_FETCH_DENY;
    else if (req_kind[0])       nxt.cause = perm.wr ? CS_OK : CS_STORE_DENY;
    else                        nxt.cause = perm.rd ? CS_OK : CS_LOAD_DENY;
  end

  rpu_resp_stage #(.PAY_W(PAY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_pay    (nxt),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_pay   (cur_bits)
  );

  assign cur       = resp_t'(cur_bits);
  assign rsp_paddr = cur.paddr;
  assign rsp_cause = cur.cause;
  assign rsp_rd    = cur.perm.rd;
  assign rsp_wr    = cur.perm.wr;
  assign rsp_ex    = cur.perm.ex;
  assign rsp_cache = cur.perm.pol;
endmodule

// File: rtl/rpu_unit_chk.sv
module rpu_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [1:0]        rsp_cause,
  input logic              rsp_rd,
  input logic              rsp_wr,
  input logic              rsp_ex,
  input logic [2:0]        rsp_cache
);
  localparam int OFF_W = ADDR_W - IDX_W;

  // R8: an accepted request shows up as a response after the edge
  a_r8_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R9: a stalled response keeps all its fields
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_cause)
      && $stable(rsp_rd) && $stable(rsp_wr) && $stable(rsp_ex) && $stable(rsp_cache)));

  // R2: the in-region offset passes through unchanged
  a_r2_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_valid && req_ready)) |->
      (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  // R6: a denial cause only appears when the matching right is missing
  a_r6_deny: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_cause != 2'd2 || !rsp_rd) && (rsp_cause != 2'd3 || !rsp_wr)
                   && (rsp_cause != 2'd1 || !rsp_ex)));

  // R4: no policy means no rights
  a_r4_none: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cache == 3'd0) |-> (!rsp_rd && !rsp_wr && !rsp_ex));

  // R4: isolate grants read and write but not execute
  a_r4_isolate: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cache == 3'd4) |-> (rsp_rd && rsp_wr && !rsp_ex));
endmodule

bind rpu_unit rpu_unit_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_vaddr (req_vaddr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_paddr (rsp_paddr),
  .rsp_cause (rsp_cause),
  .rsp_rd    (rsp_rd),
  .rsp_wr    (rsp_wr),
  .rsp_ex    (rsp_ex),
  .rsp_cache (rsp_cache)
);

// File: tb/rpu_unit_test.sv
`timescale 1ns/1ps
module rpu_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        region_mode = 1'b1;
  logic        cfg_ent_we = 1'b0;
  logic [2:0]  cfg_ent_idx = '0;
  logic [31:0] cfg_ent_base = '0;
  logic [3:0]  cfg_ent_attr = '0;
  logic        cfg_ca_we = 1'b0;
  logic [31:0] cfg_ca_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_cause;
  logic        rsp_rd, rsp_wr, rsp_ex;
  logic [2:0]  rsp_cache;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [2:0]  m_base [8];
  logic [3:0]  m_attr [8];
  logic [31:0] m_ca;

  always #10 clk = ~clk;

  rpu_unit uut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_perm(input logic [3:0] a, input bit rmode);
    // {rd, wr, ex, policy}
    case (a)
      4'd0:  return {3'b110, 3'd2};
      4'd1:  return {3'b111, 3'd2};
      4'd2:  return {3'b111, 3'd1};
      4'd3:  return {3'b001, 3'd3};
      4'd4:  return {3'b111, 3'd3};
      4'd5:  return rmode ? {3'b111, 3'd3} : 6'd0;
      4'd14: return {3'b110, 3'd4};
      default: return 6'd0;
    endcase
  endfunction

  function automatic logic [39:0] expect_rsp(input logic [31:0] va, input logic [1:0] k, input bit rmode);
    logic [2:0]  i;
    logic [3:0]  a;
    logic [5:0]  p;
    logic [31:0] pa;
    logic [1:0]  c;
    i  = va[31:29];
    a  = rmode ? m_attr[i] : m_ca[i*4 +: 4];
    p  = exp_perm(a, rmode);
    pa = rmode ? {m_base[i], va[28:0]} : va;
    if (k[1])      c = p[3] ? 2'd0 : 2'd1;
    else if (k[0]) c = p[4] ? 2'd0 : 2'd3;
    else           c = p[5] ? 2'd0 : 2'd2;
    return {pa, c, p};
  endfunction

  function automatic logic [39:0] got_rsp();
    return {rsp_paddr, rsp_cause, rsp_rd, rsp_wr, rsp_ex, rsp_cache};
  endfunction

  task automatic write_ent(input logic [2:0] i, input logic [31:0] b, input logic [3:0] a);
    @(negedge clk);
    cfg_ent_we = 1'b1; cfg_ent_idx = i; cfg_ent_base = b; cfg_ent_attr = a;
    @(negedge clk);
    cfg_ent_we = 1'b0;
    m_base[i] = b[31:29]; m_attr[i] = a;
  endtask

  task automatic write_ca(input logic [31:0] d);
    @(negedge clk);
    cfg_ca_we = 1'b1; cfg_ca_data = d;
    @(negedge clk);
    cfg_ca_we = 1'b0;
    m_ca = d;
  endtask

  task automatic lookup(input logic [31:0] va, input logic [1:0] k, input bit rmode, input string tag);
    logic [39:0] e;
    @(negedge clk);
    region_mode = rmode; req_valid = 1'b1; req_vaddr = va; req_kind = k; rsp_ready = 1'b1;
    e = expect_rsp(va, k, rmode);
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " R8 valid"}, 64'(rsp_valid), 64'd1);
    check(tag, 64'(got_rsp()), 64'(e));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [39:0] e1, e2;
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) begin m_base[i] = 3'(i); m_attr[i] = 4'd2; end
    m_ca = 32'h22222222;
    repeat (3) @(negedge clk);
    check("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R8 ready in reset-idle", 64'(req_ready), 64'd1);
    rst_n = 1'b1;

    // R1: identity bypass after reset in both modes
    lookup(32'hA123_4567, 2'd0, 1'b1, "R1 region reset");
    lookup(32'h5000_0010, 2'd2, 1'b0, "R1 plain reset");

    // R2: relocation with low base bits dropped
    write_ent(3'd3, 32'hE0FF_FFFF, 4'd1);
    lookup(32'h7ABC_DEF0, 2'd2, 1'b1, "R2 relocate");

    // R4 table in region mode, all codes, all kinds
    for (int a = 0; a < 16; a++) begin
      write_ent(3'd6, 32'h2000_0000, 4'(a));
      for (int k = 0; k < 4; k++)
        lookup(32'hC000_0100 + 32'(k), 2'(k), 1'b1, "R4 R6 table");
    end

    // R5: code 5 in both modes
    write_ca(32'h5555_5555);
    lookup(32'h1000_0000, 2'd1, 1'b0, "R5 plain code5");
    write_ent(3'd0, 32'h0, 4'd5);
    lookup(32'h1000_0000, 2'd1, 1'b1, "R5 region code5");

    // R3: nibble selection per region
    write_ca(32'hE432_10F3);
    for (int i = 0; i < 8; i++)
      lookup({3'(i), 29'h0ABC}, 2'd0, 1'b0, "R3 nibble");

    // R7: same-edge write is not seen by the request accepted at that edge
    @(negedge clk);
    region_mode = 1'b1; req_valid = 1'b1; req_vaddr = 32'h8000_0004; req_kind = 2'd0;
    e1 = expect_rsp(32'h8000_0004, 2'd0, 1'b1);
    cfg_ent_we = 1'b1; cfg_ent_idx = 3'd4; cfg_ent_base = 32'h6000_0000; cfg_ent_attr = 4'd15;
    @(negedge clk);
    cfg_ent_we = 1'b0; req_valid = 1'b0;
    m_base[4] = 3'd3; m_attr[4] = 4'd15;
    check("R7 old entry used", 64'(got_rsp()), 64'(e1));
    lookup(32'h8000_0004, 2'd0, 1'b1, "R7 new entry used");

    // R9: stall holds response, blocks new request and ignores config writes
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h4000_1234; req_kind = 2'd1; rsp_ready = 1'b0;
    e1 = expect_rsp(32'h4000_1234, 2'd1, 1'b1);
    @(negedge clk);
    req_vaddr = 32'h4000_9999; req_kind = 2'd2;
    cfg_ent_we = 1'b1; cfg_ent_idx = 3'd2; cfg_ent_base = 32'hA000_0000; cfg_ent_attr = 4'd3;
    check("R9 ready low on stall", 64'(req_ready), 64'd0);
    @(negedge clk);
    cfg_ent_we = 1'b0;
    m_base[2] = 3'd5; m_attr[2] = 4'd3;
    check("R9 held response", 64'(got_rsp()), 64'(e1));
    e2 = expect_rsp(32'h4000_9999, 2'd2, 1'b1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 drain and accept", 64'(got_rsp()), 64'(e2));

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0) write_ent(3'($urandom_range(0, 7)), $urandom, 4'($urandom_range(0, 15)));
      else if (r == 1) write_ca($urandom);
      else lookup($urandom, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "R2 R3 R4 R6 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule